// File: doc/BRIEF.md
# Port Pin-Change Interrupt Unit

This block watches an eight-pin input port and turns activity on those pins into two independent interrupt requests, vector 0 and vector 1, for a downstream interrupt controller. Every pin is first brought into the clock domain through a two-flop synchronizer. A per-pin sense setting then decides what counts as an event on that pin: any edge, a rising edge, a falling edge, or a low level.

Each vector has its own eight-bit pin mask, so a pin can feed vector 0, vector 1, both or neither. Each vector also has its own sticky flag and a two-bit priority level. An event on a masked pin always sets the vector's flag. The request and its level are only passed to the controller when the level is not off. A flag is cleared when the controller acknowledges its vector or when software writes a one to it. A new event in the same cycle as a clear takes precedence, so no event is lost.

Top module: `pin_change_irq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both flags, both requests and both level outputs go to zero, and the synchronizer and previous-value registers of every pin are loaded with 1. A port that is idle high therefore produces no event when reset is released.
- R2: A pin change first sampled at rising edge n sets the flag of a vector that it triggers at rising edge n+2. The flag is still zero after edge n+1.
- R3: The sense field of pin k is `sense_i[2k+1:2k]`. Its encodings are 0 = both edges, 1 = rising edge, 2 = falling edge and 3 = low level. Edges are found by comparing the current synchronized value of the pin with its value one cycle earlier.
- R4: In low-level mode the pin produces an event on every cycle in which its synchronized value is 0. A clear or an acknowledge therefore cannot keep the flag low while the pin stays low.
- R5: Pin k can set the flag of vector 0 only when `mask0_i[k]` is 1, and the flag of vector 1 only when `mask1_i[k]` is 1. A pin that is set in both masks sets both flags. A flag never rises without an event on a masked pin.
- R6: A flag is set by an event even when the vector's level is 0 (off). `req_o[v]` is 1 exactly when flag v is set and the vector's level is non-zero, with levels 1 = low, 2 = medium and 3 = high. The vector's level output equals its level while the request is asserted and is 0 otherwise.
- R7: `ack_i[v]` high at a rising edge clears flag v at that edge.
- R8: `flag_clr_i[v]` high at a rising edge clears flag v at that edge. A flag with neither acknowledge nor clear stays set.
- R9: If an event for vector v occurs at the same edge as a clear or an acknowledge of v, flag v is 1 after that edge.
- R10: A clear or acknowledge of one vector has no effect on the other vector's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Raw, asynchronous pin values |
| sense_i | input | 16 | Two-bit sense selection per pin; pin k at bits 2k+1:2k |
| mask0_i | input | 8 | Pin mask for vector 0 |
| mask1_i | input | 8 | Pin mask for vector 1 |
| lvl0_i | input | 2 | Priority level of vector 0 (0 = off) |
| lvl1_i | input | 2 | Priority level of vector 1 (0 = off) |
| flag_clr_i | input | 2 | Write-one-to-clear strobe; bit v clears flag v |
| ack_i | input | 2 | Acknowledge pulse from the controller; bit v for vector v |
| flag_o | output | 2 | Sticky flags, bit v for vector v |
| req_o | output | 2 | Requests forwarded to the controller |
| req_lvl0_o | output | 2 | Level of the vector 0 request, 0 when idle |
| req_lvl1_o | output | 2 | Level of the vector 1 request, 0 when idle |

## Verification
The bound checker watches the flag rules on every cycle. An event always leaves the flag set, even against a clear. A flag without an event never rises. A clear or acknowledge without an event empties the flag. A flag with neither holds. A request implies a set flag with a non-zero level output.

The checker cannot show which pins produce events, because that depends on history. Only the bench's scenarios can show that each sense mode produces events on the right pin transitions with exactly two cycles of synchronizer latency, that the masks route pins correctly, and that a low-level pin keeps re-setting its flag. The bench compares these against its reference model every cycle.

// File: rtl/pcirq_pkg.sv
// Shared encodings for the port pin-change interrupt unit.
// Assumes two-bit sense and level fields.
package pcirq_pkg;
    typedef enum logic [1:0] {
        SENSE_BOTH = 2'd0,
        SENSE_RISE = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_MED  = 2'd2,
        LVL_HIGH = 2'd3
    } level_e;

    localparam int NUM_VEC = 2;
    localparam int SENSE_W = 2;
    localparam int LVL_W   = 2;
endpackage

// File: rtl/pcirq_sync.sv
// Multi-flop synchronizer for one asynchronous bit.
// Assumes STAGES >= 2; every stage resets to RST_VAL.
module pcirq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcirq_pin_sense.sv
// Per-pin event detector: synchronizes the pin, keeps its previous
// synchronized value and reports an event according to the sense field.
// Assumes the reset value 1 (idle-high pins).
module pcirq_pin_sense
    import pcirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic [SENSE_W-1:0] sense_i,
    output logic               hit_o
);
    logic cur;
    logic prev_q;

    pcirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (cur)
    );

    // Hold the synchronized value of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= cur;
    end

    // Decode the sense selection into an event.
    always_comb begin
        unique case (sense_e'(sense_i))
            SENSE_BOTH: hit_o = cur ^ prev_q;
            SENSE_RISE: hit_o = cur & ~prev_q;
            SENSE_FALL: hit_o = ~cur & prev_q;
            SENSE_LOW:  hit_o = ~cur;
            default:    hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcirq_vector.sv
// One interrupt vector: masks pin events into a sticky flag, clears
// it on acknowledge or software write (a new event wins), and gates
// the request by the priority level.
module pcirq_vector
    import pcirq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hit_i,
    input  logic [NPINS-1:0] mask_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             clr_i,
    input  logic             ack_i,
    output logic             flag_o,
    output logic             req_o,
    output logic [LVL_W-1:0] req_lvl_o
);
    logic trig;
    logic flag_q;

    assign trig = |(hit_i & mask_i);

    // Sticky flag; a trigger overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= trig | (flag_q & ~(clr_i | ack_i));
    end

    // Forward the request only at a non-off level.
    always_comb begin
        req_o     = flag_q && (level_e'(lvl_i) != LVL_OFF);
        req_lvl_o = req_o ? lvl_i : '0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/pin_change_irq.sv
// Top of the port pin-change interrupt unit: one sense detector per
// pin and two independent masked vectors sharing those detectors.
module pin_change_irq
    import pcirq_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPINS-1:0]         pin_i,
    input  logic [SENSE_W*NPINS-1:0] sense_i,
    input  logic [NPINS-1:0]         mask0_i,
    input  logic [NPINS-1:0]         mask1_i,
    input  logic [LVL_W-1:0]         lvl0_i,
    input  logic [LVL_W-1:0]         lvl1_i,
    input  logic [NUM_VEC-1:0]       flag_clr_i,
    input  logic [NUM_VEC-1:0]       ack_i,
    output logic [NUM_VEC-1:0]       flag_o,
    output logic [NUM_VEC-1:0]       req_o,
    output logic [LVL_W-1:0]         req_lvl0_o,
    output logic [LVL_W-1:0]         req_lvl1_o
);
    logic [NPINS-1:0] pin_hit;
    logic [NPINS-1:0] mask_a [NUM_VEC];
    logic [LVL_W-1:0] lvl_a  [NUM_VEC];
    logic [LVL_W-1:0] rlvl_a [NUM_VEC];

    assign mask_a[0] = mask0_i;
    assign mask_a[1] = mask1_i;
    assign lvl_a[0]  = lvl0_i;
    assign lvl_a[1]  = lvl1_i;
    assign req_lvl0_o = rlvl_a[0];
    assign req_lvl1_o = rlvl_a[1];

    for (genvar k = 0; k < NPINS; k++) begin : g_pin
        pcirq_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[k]),
            .sense_i (sense_i[SENSE_W*k +: SENSE_W]),
            .hit_o   (pin_hit[k])
        );
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        pcirq_vector #(.NPINS(NPINS)) u_vec (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (pin_hit),
            .mask_i    (mask_a[v]),
            .lvl_i     (lvl_a[v]),
            .clr_i     (flag_clr_i[v]),
            .ack_i     (ack_i[v]),
            .flag_o    (flag_o[v]),
            .req_o     (req_o[v]),
            .req_lvl_o (rlvl_a[v])
        );
    end
endmodule

// File: rtl/pcirq_chk.sv
// Assertion checker for pin_change_irq, attached with bind.
// Relates the pin events from the detectors to the vector flags.
module pcirq_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] hit,
    input logic [NPINS-1:0] mask0,
    input logic [NPINS-1:0] mask1,
    input logic [1:0]       clr,
    input logic [1:0]       ack,
    input logic [1:0]       flag,
    input logic [1:0]       req,
    input logic [3:0]       rlvl
);
    logic [1:0] trig;
    assign trig = {|(hit & mask1), |(hit & mask0)};

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag == 2'b00 && req == 2'b00)); // R1

    for (genvar v = 0; v < 2; v++) begin : g_v
        AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            trig[v] |=> flag[v]); // R9
        AST_FLAG_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag[v] && !trig[v]) |=> !flag[v]); // R5
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[v] && !trig[v]) |=> !flag[v]); // R7
        AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[v] && !trig[v]) |=> !flag[v]); // R8
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[v] && !ack[v] && !clr[v]) |=> flag[v]); // R8
        AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            req[v] |-> (flag[v] && rlvl[2*v +: 2] != 2'd0)); // R6
        AST_IDLE_LVL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !req[v] |-> (rlvl[2*v +: 2] == 2'd0)); // R6
    end
endmodule

bind pin_change_irq pcirq_chk #(.NPINS(NPINS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (pin_hit),
    .mask0 (mask0_i),
    .mask1 (mask1_i),
    .clr   (flag_clr_i),
    .ack   (ack_i),
    .flag  (flag_o),
    .req   (req_o),
    .rlvl  ({req_lvl1_o, req_lvl0_o})
);

// File: tb/pin_change_irq_tb.sv
`timescale 1ns/1ps
module pin_change_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = 8'hFF;
    logic [15:0] sense_i = 16'h5555;
    logic [7:0]  mask0_i = 8'h00, mask1_i = 8'h00;
    logic [1:0]  lvl0_i = 2'd0, lvl1_i = 2'd0;
    logic [1:0]  flag_clr_i = 2'b00, ack_i = 2'b00;
    logic [1:0]  flag_o, req_o, req_lvl0_o, req_lvl1_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    pin_change_irq u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sense_i(sense_i),
        .mask0_i(mask0_i), .mask1_i(mask1_i), .lvl0_i(lvl0_i), .lvl1_i(lvl1_i),
        .flag_clr_i(flag_clr_i), .ack_i(ack_i), .flag_o(flag_o), .req_o(req_o),
        .req_lvl0_o(req_lvl0_o), .req_lvl1_o(req_lvl1_o)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: history of pin samples, one entry per edge.
    logic [7:0] hq [$];
    bit   [1:0] m_flag;

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            hq = '{8'hFF, 8'hFF, 8'hFF};
            m_flag = 2'b00;
        end else begin
            logic [7:0] s, p, hit;
            s = hq[hq.size()-2];
            p = hq[hq.size()-3];
            for (int k = 0; k < 8; k++) begin
                case (sense_i[2*k +: 2])
                    2'd0: hit[k] = s[k] != p[k];
                    2'd1: hit[k] = s[k] && !p[k];
                    2'd2: hit[k] = !s[k] && p[k];
                    default: hit[k] = !s[k];
                endcase
            end
            m_flag[0] = ((hit & mask0_i) != 0) || (m_flag[0] && !flag_clr_i[0] && !ack_i[0]);
            m_flag[1] = ((hit & mask1_i) != 0) || (m_flag[1] && !flag_clr_i[1] && !ack_i[1]);
            hq.push_back(pin_i);
            void'(hq.pop_front());
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            bit [1:0] er;
            er[0] = m_flag[0] && lvl0_i != 0;
            er[1] = m_flag[1] && lvl1_i != 0;
            check(cur_req, "flag", flag_o, m_flag);
            check(cur_req, "req", req_o, er);
            check(cur_req, "lvl0", req_lvl0_o, er[0] ? lvl0_i : 0);
            check(cur_req, "lvl1", req_lvl1_o, er[1] ? lvl1_i : 0);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr(logic [1:0] v);
        flag_clr_i = v; step(1); flag_clr_i = 2'b00;
    endtask

    task automatic pulse_ack(logic [1:0] v);
        ack_i = v; step(1); ack_i = 2'b00;
    endtask

    task automatic finish_up();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        cur_req = "R1";
        check("R1", "flag after reset", flag_o, 0);
        check("R1", "req after reset", req_o, 0);
        step(3);

        // R2: latency of exactly two edges after the sampling edge
        cur_req = "R2";
        mask0_i = 8'h01; lvl0_i = 2'd1;
        pin_i[0] = 1'b0; step(5);
        check("R2", "falling edge ignored in rising mode", flag_o[0], 0);
        pin_i[0] = 1'b1;
        step(2);
        check("R2", "flag after one edge past sample", flag_o[0], 0);
        step(1);
        check("R2", "flag after two edges past sample", flag_o[0], 1);
        check("R2", "request level", req_lvl0_o, 1);
        pulse_clr(2'b01); step(1);
        check("R8", "flag after clear", flag_o[0], 0);
        pulse_clr(2'b00); step(1);

        // R3: sense modes on different pins
        cur_req = "R3";
        sense_i = 16'h5555;
        sense_i[3:2] = 2'd2; sense_i[5:4] = 2'd0;
        mask0_i = 8'h06;
        pin_i[1] = 1'b0; step(4); pulse_clr(2'b01); step(3);
        pin_i[1] = 1'b1; step(4);
        check("R3", "rising ignored in falling mode", flag_o[0], 0);
        pin_i[2] = 1'b0; step(4); pulse_clr(2'b01); step(3);
        pin_i[2] = 1'b1; step(4);
        check("R3", "rising seen in both-edge mode", flag_o[0], 1);
        pulse_clr(2'b01); step(3);

        // R4: low level keeps re-setting the flag
        cur_req = "R4";
        sense_i[7:6] = 2'd3; mask1_i = 8'h08; lvl1_i = 2'd3;
        pin_i[3] = 1'b0; step(4);
        pulse_clr(2'b10); pulse_ack(2'b10); step(1);
        check("R4", "flag held by low level", flag_o[1], 1);
        check("R6", "high level forwarded", req_lvl1_o, 3);
        pin_i[3] = 1'b1; step(4);
        pulse_clr(2'b10); step(1);
        check("R4", "flag cleared after pin high", flag_o[1], 0);

        // R5: routing to both vectors, unmasked pin ignored
        cur_req = "R5";
        sense_i[9:8] = 2'd0; sense_i[11:10] = 2'd0;
        mask0_i = 8'h10; mask1_i = 8'h10;
        pin_i[5] = 1'b0; step(5);
        check("R5", "unmasked pin ignored", flag_o, 0);
        pin_i[4] = 1'b0; step(4);
        check("R5", "pin in both masks", flag_o, 3);
        pulse_clr(2'b11); step(2);

        // R6: flag set with level off, no request
        cur_req = "R6";
        lvl0_i = 2'd0;
        pin_i[4] = 1'b1; step(4);
        check("R6", "flag with level off", flag_o[0], 1);
        check("R6", "no request with level off", req_o[0], 0);
        lvl0_i = 2'd2; step(1);
        check("R6", "request at medium", req_lvl0_o, 2);

        // R7 / R10: acknowledge clears only its own vector
        cur_req = "R7";
        pulse_ack(2'b01); step(1);
        check("R7", "ack clears vector 0", flag_o[0], 0);
        check("R10", "vector 1 untouched", flag_o[1], 1);
        cur_req = "R10";
        pulse_clr(2'b10); step(1);

        // R9: event on the same edge as a clear and an ack
        cur_req = "R9";
        mask0_i = 8'h08; sense_i[7:6] = 2'd3;
        pin_i[3] = 1'b0; step(4);
        pin_i[3] = 1'b1;
        flag_clr_i = 2'b01; ack_i = 2'b01; step(1);
        flag_clr_i = 2'b00; ack_i = 2'b00;
        check("R9", "trigger beats clear", flag_o[0], 1);
        step(2);
        pulse_clr(2'b11); step(2);

        // Random stress against the model
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            pin_i = $urandom();
            if (i % 50 == 0) begin
                sense_i = $urandom(); mask0_i = $urandom(); mask1_i = $urandom();
                lvl0_i = $urandom(); lvl1_i = $urandom();
            end
            flag_clr_i = (($urandom() % 4) == 0) ? 2'($urandom()) : 2'b00;
            ack_i = (($urandom() % 4) == 0) ? 2'($urandom()) : 2'b00;
            step(1);
        end
        flag_clr_i = 2'b00; ack_i = 2'b00;
        step(2);
        finish_up();
    end
endmodule